// File: doc/BRIEF.md
# Byte-Lane Data Memory Access Unit

This block connects a 16-bit processor datapath to a data RAM that is built as two byte-wide halves sharing one word address. Each request carries a 16-bit byte address, a byte/word size flag, a read/write selector, write data, an extension mode and the current image of the destination register. The low byte of a word lives at the even address and the high byte at the odd address. A byte read fetches the containing word and moves the selected byte onto the low 8 bits. A byte write enables only the matching lane. Both results appear one clock after the request, which matches the latency of synchronous RAM.

A word access to an odd address raises a one-cycle address-error trap pulse and registers the faulting address. A misaligned read still returns the even-aligned word. A misaligned write changes nothing. Addresses at or above the implemented size read as zero and ignore writes. The same holds for unoccupied blocks of the low register window, which an occupancy mask parameter describes. The block also produces the updated register image: a byte load keeps the register's high byte, and sign or zero extension can be selected in its place.

Top module: `dmem_lane_unit`

## Requirements
- R1: A byte read returns the byte picked by address bit 0 (0 = low lane, 1 = high lane) on rsp_rdata[7:0], with rsp_rdata[15:8] = 0, and asserts rsp_valid, all one clock after the request.
- R2: A word read at an even address returns {high lane, low lane} of that word one clock after the request.
- R3: A byte write takes its data from req_wdata[7:0] and writes only the lane selected by address bit 0, so lane_we is 2'b01 or 2'b10. The other byte of the word keeps its value.
- R4: A word write at an even address writes req_wdata[7:0] to the low lane and req_wdata[15:8] to the high lane, so lane_we is 2'b11.
- R5: A word request at an odd address gives trap_pulse = 1 for the following cycle and loads trap_addr with the request address. Byte requests never raise trap_pulse.
- R6: A misaligned word read still completes and returns the word at the address with bit 0 cleared. A misaligned word write drives lane_we = 2'b00 and leaves the memory unchanged.
- R7: Any address at or above MEM_BYTES (default 2048) reads as zero and is never written (lane_we = 2'b00). A byte load from such an address yields 0x00 as the loaded byte.
- R8: Inside the window below WIN_BYTES (default 256), blocks of BLK_BYTES (default 32) whose OCC_MASK bit is 0 read as zero and ignore writes. The default mask is 8'b1010_1101, bit i for block i. Occupied blocks behave as ordinary RAM.
- R9: rsp_reg gives the new register image for a read, with req_ext encoded as 0 = keep, 1 = sign, 2 = zero and 3 acting as keep. For a byte load with keep, the result is {reg_in[15:8], byte}. For a word load with keep, the result is the word. Sign copies bit 7 of the loaded value into bits 15:8, and zero clears bits 15:8.
- R10: While reset is high, and in the first cycle after it, rsp_valid, trap_pulse, lane_we and trap_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 16 | Byte effective address |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| req_ext | input | 2 | Load extension: 0 keep, 1 sign, 2 zero |
| reg_in | input | 16 | Current destination register image |
| rsp_valid | output | 1 | Read result valid |
| rsp_rdata | output | 16 | Aligned read data |
| rsp_reg | output | 16 | Merged register image |
| lane_we | output | 2 | Lane write enables applied, one cycle after request |
| trap_pulse | output | 1 | Address-error trap request pulse |
| trap_addr | output | 16 | Address of the last faulting request |

## Verification
The bench first writes whole words and then reads them back three ways: as a word, and as each of the two bytes. This separates lane selection from word assembly. Byte writes to each lane, followed by word reads, show whether the neighbouring lane was left alone. Byte loads run under every extension mode, with register images whose high byte is distinctive and loaded bytes with bit 7 both set and clear, so keep, sign and zero give different results. Odd-address word reads and writes, out-of-range addresses that alias onto written RAM, and unoccupied and occupied window blocks each show whether the trap is raised, whether the write is blocked and whether the read data is masked.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  typedef enum logic [1:0] {
    EXT_KEEP = 2'd0,
    EXT_SIGN = 2'd1,
    EXT_ZERO = 2'd2
  } ext_e;

  localparam int LANES  = 2;
  localparam int LANE_W = 8;
endpackage

// File: rtl/dmem_decode.sv
module dmem_decode #(
  parameter int ADDR_W    = 16,
  parameter int MEM_BYTES = 2048,
  parameter int WIN_BYTES = 256,
  parameter int BLK_BYTES = 32,
  parameter logic [WIN_BYTES/BLK_BYTES-1:0] OCC_MASK = 8'b1010_1101,
  localparam int RAM_AW   = $clog2(MEM_BYTES/2)
) (
  input  logic              valid,
  input  logic              write,
  input  logic              is_byte,
  input  logic [ADDR_W-1:0] addr,
  output logic [RAM_AW-1:0] word_idx,
  output logic [1:0]        lane_en,
  output logic              misaligned,
  output logic              mapped
);
  localparam int WIN_AW = $clog2(WIN_BYTES);
  localparam int BLK_SH = $clog2(BLK_BYTES);
  localparam logic [ADDR_W:0] MEM_LIM = MEM_BYTES[ADDR_W:0];
  localparam logic [ADDR_W:0] WIN_LIM = WIN_BYTES[ADDR_W:0];

  logic in_range, in_win, occupied, wr_ok;
  logic [WIN_AW-BLK_SH-1:0] blk;

  always_comb begin
    word_idx   = addr[RAM_AW:1];
    in_range   = {1'b0, addr} < MEM_LIM;
    in_win     = {1'b0, addr} < WIN_LIM;
    blk        = addr[WIN_AW-1:BLK_SH];
    occupied   = !in_win || OCC_MASK[blk];
    mapped     = in_range && occupied;
    misaligned = !is_byte && addr[0];
    wr_ok      = valid && write && mapped && !misaligned;
    lane_en[0] = wr_ok && (!is_byte || !addr[0]);
    lane_en[1] = wr_ok && (!is_byte || addr[0]);
  end
endmodule

// File: rtl/dmem_lane_ram.sv
module dmem_lane_ram #(
  parameter int AW = 10,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/dmem_merge.sv
module dmem_merge
  import dmem_pkg::*;
(
  input  logic [15:0] word_q,
  input  logic        is_byte,
  input  logic        byte_sel,
  input  logic        zero,
  input  logic [1:0]  ext,
  input  logic [15:0] reg_img,
  output logic [15:0] rdata,
  output logic [15:0] rreg
);
  logic [15:0] word;
  logic [7:0]  pick;

  always_comb begin
    word = zero ? 16'h0000 : word_q;
    pick = byte_sel ? word[15:8] : word[7:0];
    rdata = is_byte ? {8'h00, pick} : word;
    case (ext)
      EXT_SIGN: rreg = {{8{rdata[7]}}, rdata[7:0]};
      EXT_ZERO: rreg = {8'h00, rdata[7:0]};
      default: begin
        if (is_byte) begin
          rreg = reg_img;
          rreg[7:0] = pick;
        end else begin
          rreg = word;
        end
      end
    endcase
  end
endmodule

// File: rtl/dmem_lane_unit.sv
module dmem_lane_unit
  import dmem_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MEM_BYTES = 2048,
  parameter int WIN_BYTES = 256,
  parameter int BLK_BYTES = 32,
  parameter logic [WIN_BYTES/BLK_BYTES-1:0] OCC_MASK = 8'b1010_1101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_byte,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_ext,
  input  logic [15:0]       reg_in,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic [15:0]       rsp_reg,
  output logic [1:0]        lane_we,
  output logic              trap_pulse,
  output logic [ADDR_W-1:0] trap_addr
);
  localparam int RAM_AW = $clog2(MEM_BYTES/2);

  logic [RAM_AW-1:0] word_idx;
  logic [1:0]        lane_en;
  logic              misaligned, mapped;
  logic [LANE_W-1:0] lane_wd [LANES];
  logic [LANE_W-1:0] lane_q  [LANES];

  logic        s_byte, s_sel, s_zero;
  logic [1:0]  s_ext;
  logic [15:0] s_reg;

  dmem_decode #(
    .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .WIN_BYTES(WIN_BYTES),
    .BLK_BYTES(BLK_BYTES), .OCC_MASK(OCC_MASK)
  ) u_dec (
    .valid(req_valid), .write(req_write), .is_byte(req_byte), .addr(req_addr),
    .word_idx(word_idx), .lane_en(lane_en), .misaligned(misaligned), .mapped(mapped)
  );

  assign lane_wd[0] = req_wdata[7:0];
  assign lane_wd[1] = req_byte ? req_wdata[7:0] : req_wdata[15:8];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dmem_lane_ram #(.AW(RAM_AW), .DW(LANE_W)) u_ram (
      .clk(clk), .we(lane_en[g]), .addr(word_idx),
      .wdata(lane_wd[g]), .rdata(lane_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      lane_we    <= 2'b00;
      trap_pulse <= 1'b0;
      trap_addr  <= '0;
      s_byte     <= 1'b0;
      s_sel      <= 1'b0;
      s_zero     <= 1'b1;
      s_ext      <= 2'd0;
      s_reg      <= '0;
    end else begin
      rsp_valid  <= req_valid && !req_write;
      lane_we    <= lane_en;
      trap_pulse <= req_valid && misaligned;
      if (req_valid && misaligned) trap_addr <= req_addr;
      s_byte     <= req_byte;
      s_sel      <= req_addr[0];
      s_zero     <= !mapped;
      s_ext      <= req_ext;
      s_reg      <= reg_in;
    end
  end

  dmem_merge u_merge (
    .word_q({lane_q[1], lane_q[0]}), .is_byte(s_byte), .byte_sel(s_sel),
    .zero(s_zero), .ext(s_ext), .reg_img(s_reg),
    .rdata(rsp_rdata), .rreg(rsp_reg)
  );
endmodule

// File: rtl/dmem_lane_unit_chk.sv
module dmem_lane_unit_chk #(
  parameter int ADDR_W    = 16,
  parameter int MEM_BYTES = 2048
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_byte,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_ext,
  input logic              rsp_valid,
  input logic [15:0]       rsp_rdata,
  input logic [15:0]       rsp_reg,
  input logic [1:0]        lane_we,
  input logic              trap_pulse,
  input logic [ADDR_W-1:0] trap_addr
);
  localparam logic [ADDR_W:0] LIM = MEM_BYTES[ADDR_W:0];

  assert_byte_low_lane_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_byte) |=> (rsp_valid && rsp_rdata[15:8] == 8'h00));

  assert_byte_write_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_byte) |=> $onehot0(lane_we));

  assert_odd_word_trap_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_byte && req_addr[0]) |=> (trap_pulse && trap_addr == $past(req_addr)));

  assert_byte_no_trap_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_byte) |=> !trap_pulse);

  assert_mis_write_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !req_byte && req_addr[0]) |=> (lane_we == 2'b00));

  assert_oor_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && ({1'b0, req_addr} >= LIM)) |=> (rsp_rdata == 16'h0000));

  assert_zero_ext_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_ext == 2'd2) |=> (rsp_reg[15:8] == 8'h00));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !trap_pulse && lane_we == 2'b00));
endmodule

bind dmem_lane_unit dmem_lane_unit_chk #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_chk (.*);

// File: tb/dmem_lane_unit_bench.sv
module dmem_lane_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MEMB = 2048;
  localparam logic [7:0] OCC = 8'b1010_1101;

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 0, req_write = 0, req_byte = 0;
  logic [15:0] req_addr = 0, req_wdata = 0, reg_in = 0;
  logic [1:0]  req_ext = 0;
  logic        rsp_valid, trap_pulse;
  logic [15:0] rsp_rdata, rsp_reg, trap_addr;
  logic [1:0]  lane_we;

  int n_tests = 0, n_fail = 0, cycles = 0;

  typedef struct {
    bit          rd;
    logic [15:0] rdata;
    logic [15:0] rreg;
    bit          trap;
    logic [15:0] taddr;
    logic [1:0]  we;
    string       tag;
  } exp_t;
  exp_t q[$];
  logic [7:0] model [0:MEMB-1];
  logic [15:0] last_taddr = 0;

  dmem_lane_unit u_dmem_lane_unit (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit mapped(input logic [15:0] a);
    if (a >= 16'(MEMB)) return 0;
    if (a < 16'd256) return OCC[a[7:5]];
    return 1;
  endfunction

  task automatic issue(input bit wr, input bit by, input logic [15:0] a,
                       input logic [15:0] wd, input logic [1:0] ext,
                       input logic [15:0] rin, input string tag);
    exp_t e;
    int wa;
    logic [15:0] word, ld;
    bit mis;
    mis = !by && a[0];
    wa = int'(a & 16'hFFFE);
    e.tag = tag; e.rd = !wr; e.trap = mis;
    if (mis) last_taddr = a;
    e.taddr = last_taddr;
    e.we = 2'b00; e.rdata = 0; e.rreg = 0;
    if (wr) begin
      if (mapped(a) && !mis) e.we = by ? (a[0] ? 2'b10 : 2'b01) : 2'b11;
      if (e.we[0]) model[wa] = wd[7:0];
      if (e.we[1]) model[wa+1] = by ? wd[7:0] : wd[15:8];
    end else begin
      word = mapped(a) ? {model[wa+1], model[wa]} : 16'h0000;
      ld = by ? {8'h00, (a[0] ? word[15:8] : word[7:0])} : word;
      e.rdata = ld;
      case (ext)
        2'd1: e.rreg = {{8{ld[7]}}, ld[7:0]};
        2'd2: e.rreg = {8'h00, ld[7:0]};
        default: e.rreg = by ? {rin[15:8], ld[7:0]} : ld;
      endcase
    end
    req_valid = 1; req_write = wr; req_byte = by; req_addr = a;
    req_wdata = wd; req_ext = ext; reg_in = rin;
    q.push_back(e);
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin : monitor
    exp_t e;
    bit v;
    forever begin
      @(posedge clk);
      v = req_valid && !rst;
      @(negedge clk);
      if (v && q.size() > 0) begin
        e = q.pop_front();
        n_tests++;
        if (rsp_valid !== e.rd || lane_we !== e.we || trap_pulse !== e.trap ||
            trap_addr !== e.taddr ||
            (e.rd && (rsp_rdata !== e.rdata || rsp_reg !== e.rreg))) begin
          n_fail++;
          $display("FAIL %s: got v=%0b rd=%h reg=%h we=%b trap=%0b ta=%h exp v=%0b rd=%h reg=%h we=%b trap=%0b ta=%h",
                   e.tag, rsp_valid, rsp_rdata, rsp_reg, lane_we, trap_pulse, trap_addr,
                   e.rd, e.rdata, e.rreg, e.we, e.trap, e.taddr);
        end
      end
    end
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: got %0d cycles exp <= 5000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    n_tests++;
    if (rsp_valid !== 0 || trap_pulse !== 0 || lane_we !== 0 || trap_addr !== 0) begin
      n_fail++;
      $display("FAIL R10 reset: got v=%0b trap=%0b we=%b ta=%h exp all zero",
               rsp_valid, trap_pulse, lane_we, trap_addr);
    end
    rst = 0;
    @(negedge clk);
    n_tests++;
    if (rsp_valid !== 0 || trap_pulse !== 0 || lane_we !== 0 || trap_addr !== 0) begin
      n_fail++;
      $display("FAIL R10 after reset: got v=%0b trap=%0b we=%b ta=%h exp all zero",
               rsp_valid, trap_pulse, lane_we, trap_addr);
    end
    issue(1, 0, 16'h0400, 16'hA1B2, 0, 0, "R4 word write");
    issue(1, 0, 16'h0402, 16'h8C7D, 0, 0, "R4 word write 2");
    issue(0, 0, 16'h0400, 0, 0, 0, "R2 word read");
    issue(0, 1, 16'h0400, 0, 0, 16'h5A00, "R1 R9 byte low keep");
    issue(0, 1, 16'h0401, 0, 0, 16'hC3FF, "R1 R9 byte high keep");
    issue(0, 1, 16'h0402, 0, 1, 16'hFFFF, "R9 sign bit7 clear");
    issue(0, 1, 16'h0403, 0, 1, 16'h0000, "R9 sign bit7 set");
    issue(0, 1, 16'h0403, 0, 2, 16'hFFFF, "R9 zero ext");
    issue(0, 1, 16'h0403, 0, 3, 16'h9900, "R9 ext 3 keeps");
    issue(0, 0, 16'h0402, 0, 1, 0, "R9 word sign");
    issue(1, 1, 16'h0401, 16'h00EE, 0, 0, "R3 byte write high");
    issue(0, 0, 16'h0400, 0, 0, 0, "R3 high lane only");
    issue(1, 1, 16'h0400, 16'h1234, 0, 0, "R3 byte write low");
    issue(0, 0, 16'h0400, 0, 0, 0, "R3 low lane only");
    issue(0, 0, 16'h0403, 0, 0, 0, "R5 R6 misaligned read");
    issue(1, 0, 16'h0401, 16'hFFFF, 0, 0, "R5 R6 misaligned write");
    issue(0, 0, 16'h0400, 0, 0, 0, "R6 write suppressed");
    issue(0, 1, 16'h0403, 0, 0, 16'h1100, "R5 byte odd no trap");
    issue(1, 0, 16'h0100, 16'h1111, 0, 0, "R7 alias target write");
    issue(1, 0, 16'h0900, 16'h5555, 0, 0, "R7 oor write");
    issue(0, 0, 16'h0100, 0, 0, 0, "R7 alias unchanged");
    issue(0, 0, 16'h0900, 0, 0, 0, "R7 oor word read");
    issue(0, 1, 16'hFFFF, 0, 0, 16'h3300, "R7 oor byte keep");
    issue(1, 0, 16'h0024, 16'h7777, 0, 0, "R8 unoccupied write");
    issue(0, 0, 16'h0024, 0, 0, 0, "R8 unoccupied read");
    issue(1, 0, 16'h0044, 16'h4321, 0, 0, "R8 occupied write");
    issue(0, 0, 16'h0044, 0, 0, 0, "R8 occupied read");
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule